// File: doc/BRIEF.md
# Vector-Driven Pin Go/No-Go Tester

This block runs a stored list of test vectors against a device sitting in a 24-pin socket and returns one pass or fail verdict. Each vector entry is read from an external memory with one cycle of read latency. An entry holds four 24-bit words: stimulus, expected response, care mask and device-output mask. The block drives every socket pin from one bit of a registered drive word. On pins marked as device outputs it drives the complement of the expected value. A pin whose output is missing or open therefore reads back the forced, wrong value, and the vector fails. On a tristate pin whose output is disabled, the stimulus value is expected to read back unchanged.

After loading a vector, the block waits a programmable number of settle cycles. It then strobes three one-hot readback groups of eight pins each, one per cycle, and assembles the 24-bit response. It compares that response with the expected word on the pins whose care bit is set. The run stops at the first mismatch and records the failing vector index and the mismatching pins. If every vector matches, the block reports a pass. The verdict stays on the outputs until the next start.

Top module: `pin_vector_tester`

## Requirements
- R1: While reset is high and on the first cycle after it is released, `done`, `pass`, `grp_sel`, `pin_drive`, `vec_rd`, `fail_index` and `fail_bits` are all zero.
- R2: For each pin, `pin_drive` takes the complement of the expected bit when that pin's `vec_dout` bit is 1, and takes the stimulus bit when it is 0. The word is loaded once per vector and held until the next vector is loaded, including after the run ends.
- R3: `grp_sel` is never more than one-hot. Bit 0 selects pins 7:0, bit 1 selects pins 15:8 and bit 2 selects pins 23:16. Each bit is high for exactly one cycle, in that order, and `rb_data` is captured in the same cycle. `pin_drive` does not change while a group is selected.
- R4: With settle value S, `grp_sel[0]` first rises S+2 clock edges after the edge that accepts `start`. Each vector takes S+6 cycles.
- R5: A vector passes when `(captured ^ expected) & care` is zero. Pins whose care bit is 0 never cause a failure.
- R6: If all N vectors pass, `done` and `pass` are both 1 exactly N*(S+6) edges after the accepting edge.
- R7: On the first failing vector, the run stops. `done`=1 and `pass`=0, `fail_index` holds that vector's index, and `fail_bits` holds the masked mismatch word.
- R8: A start with `vec_count` = 0 sets `done` and `pass` at the accepting edge itself.
- R9: A `start` pulse while a run is in progress has no effect on the run's length or verdict.
- R10: `done` and the verdict stay constant until the next `start`. The edge that accepts a new `start` on a non-empty list clears `done` and `pass`.
- R11: For each vector, `vec_rd` is high for exactly one cycle with `vec_addr` equal to the vector index, and the vector data is taken on the following cycle. A passing run of N vectors issues N reads, and the last read is at address N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a run when idle |
| vec_count | input | ADDR_W+1 | Number of vectors in the list, latched at start |
| settle_cycles | input | SETTLE_W | Settle delay after drive, latched at start |
| vec_rd | output | 1 | Vector memory read strobe |
| vec_addr | output | ADDR_W | Vector memory read address |
| vec_stim | input | PINS | Stimulus word of the vector read |
| vec_expect | input | PINS | Expected response word |
| vec_care | input | PINS | Care mask, 1 = compare pin |
| vec_dout | input | PINS | 1 = pin is a device output, drive complement of expected |
| pin_drive | output | PINS | Drive word to the socket pins |
| grp_sel | output | NGRP | One-hot readback group select |
| rb_data | input | GRP_W | Readback data of the selected group |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Go verdict, valid when done |
| fail_index | output | ADDR_W | Index of the first failing vector |
| fail_bits | output | PINS | Masked mismatch pins of that vector |

## Verification
The bench builds the block with 24 pins, 8-bit groups, a 4-bit vector address (a 16-entry memory) and a 4-bit settle counter. The small address width keeps the memory model tiny while still allowing runs of 0, 7 and 8 vectors. The 4-bit settle counter lets the bench try the zero-settle path and several non-zero settle delays, so the S+6 timing can be checked exactly. The socket model behaves as an enable-controlled eight-bit buffer with open-pin injection and garbage readback on unused pins. This setup makes it possible to test the inverted-drive detection, disabled-output readback and masking against real mismatches.

// File: rtl/pvt_pkg.sv
package pvt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_SETTLE,
    ST_SAMPLE
  } pvt_state_e;

endpackage

// File: rtl/pvt_drive_former.sv
module pvt_drive_former #(
  parameter int PINS = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load,
  input  logic [PINS-1:0] stim_i,
  input  logic [PINS-1:0] expect_i,
  input  logic [PINS-1:0] care_i,
  input  logic [PINS-1:0] dout_i,
  output logic [PINS-1:0] drive_o,
  output logic [PINS-1:0] expect_o,
  output logic [PINS-1:0] care_o
);

  // One registered drive bit per socket pin; device outputs get the
  // complement of their expected value so an open output reads wrong.
  for (genvar p = 0; p < PINS; p++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst) begin
        drive_o[p] <= 1'b0;
      end else if (load) begin
        drive_o[p] <= dout_i[p] ? ~expect_i[p] : stim_i[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_o <= '0;
      care_o   <= '0;
    end else if (load) begin
      expect_o <= expect_i;
      care_o   <= care_i;
    end
  end

  // R2: drive word only moves on a load
  p_drive_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(drive_o));

endmodule

// File: rtl/pvt_capture.sv
module pvt_capture #(
  parameter int PINS  = 24,
  parameter int GRP_W = 8,
  localparam int NGRP = PINS / GRP_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             begin_i,
  input  logic [GRP_W-1:0] rb_data_i,
  output logic [NGRP-1:0]  grp_sel_o,
  output logic [PINS-1:0]  cap_o,
  output logic             done_o
);

  logic [GRP_W-1:0] bank [NGRP];

  // Walking one-hot strobe: one group per cycle, shifts out after the last.
  always_ff @(posedge clk) begin
    if (rst) begin
      grp_sel_o <= '0;
      done_o    <= 1'b0;
    end else begin
      done_o <= grp_sel_o[NGRP-1];
      if (begin_i) begin
        grp_sel_o <= NGRP'(1);
      end else begin
        grp_sel_o <= grp_sel_o << 1;
      end
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst) begin
        bank[g] <= '0;
      end else if (grp_sel_o[g]) begin
        bank[g] <= rb_data_i;
      end
    end
    assign cap_o[g*GRP_W +: GRP_W] = bank[g];
  end

  // R3: at most one group on the read bus
  p_grp_onehot_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grp_sel_o));

  // R3: a finished sweep is reported only after the top group was strobed
  p_sweep_end_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(grp_sel_o[NGRP-1]));

endmodule

// File: rtl/pvt_verdict.sv
module pvt_verdict #(
  parameter int PINS   = 24,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              empty_i,
  input  logic              judge_i,
  input  logic              last_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [PINS-1:0]   cap_i,
  input  logic [PINS-1:0]   expect_i,
  input  logic [PINS-1:0]   care_i,
  output logic              miss_o,
  output logic              done_o,
  output logic              pass_o,
  output logic [ADDR_W-1:0] fail_index_o,
  output logic [PINS-1:0]   fail_bits_o
);

  logic [PINS-1:0] diff;

  assign diff   = (cap_i ^ expect_i) & care_i;
  assign miss_o = |diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o       <= 1'b0;
      pass_o       <= 1'b0;
      fail_index_o <= '0;
      fail_bits_o  <= '0;
    end else if (clear_i) begin
      done_o       <= empty_i;
      pass_o       <= empty_i;
      fail_index_o <= '0;
      fail_bits_o  <= '0;
    end else if (judge_i) begin
      if (miss_o) begin
        done_o       <= 1'b1;
        pass_o       <= 1'b0;
        fail_index_o <= idx_i;
        fail_bits_o  <= diff;
      end else if (last_i) begin
        done_o <= 1'b1;
        pass_o <= 1'b1;
      end
    end
  end

  // R6: a go verdict is never shown without done
  p_pass_done_r6: assert property (@(posedge clk) disable iff (rst)
    pass_o |-> done_o);

  // R7: a no-go verdict always names at least one pin
  p_fail_bits_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !pass_o) |-> (fail_bits_o != '0));

  // R10: verdict frozen until a new start is accepted
  p_done_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (done_o && !clear_i) |=> (done_o && $stable(pass_o) && $stable(fail_bits_o)));

endmodule

// File: rtl/pin_vector_tester.sv
module pin_vector_tester
  import pvt_pkg::*;
#(
  parameter int PINS     = 24,
  parameter int GRP_W    = 8,
  parameter int ADDR_W   = 8,
  parameter int SETTLE_W = 8,
  localparam int NGRP    = PINS / GRP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W:0]   vec_count,
  input  logic [SETTLE_W-1:0] settle_cycles,
  output logic              vec_rd,
  output logic [ADDR_W-1:0] vec_addr,
  input  logic [PINS-1:0]   vec_stim,
  input  logic [PINS-1:0]   vec_expect,
  input  logic [PINS-1:0]   vec_care,
  input  logic [PINS-1:0]   vec_dout,
  output logic [PINS-1:0]   pin_drive,
  output logic [NGRP-1:0]   grp_sel,
  input  logic [GRP_W-1:0]  rb_data,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_index,
  output logic [PINS-1:0]   fail_bits
);

  pvt_state_e          state;
  logic [ADDR_W-1:0]   idx;
  logic [ADDR_W:0]     count_q;
  logic [SETTLE_W-1:0] settle_q;
  logic [SETTLE_W-1:0] settle_cnt;

  logic            accept;
  logic            load;
  logic            cap_begin;
  logic            cap_done;
  logic            judge;
  logic            last;
  logic            miss;
  logic [PINS-1:0] cap_word;
  logic [PINS-1:0] exp_q;
  logic [PINS-1:0] care_q;

  assign accept    = (state == ST_IDLE) && start;
  assign load      = (state == ST_LOAD);
  assign cap_begin = (load && settle_q == '0) ||
                     (state == ST_SETTLE && settle_cnt == SETTLE_W'(1));
  assign judge     = (state == ST_SAMPLE) && cap_done;
  assign last      = ({1'b0, idx} == count_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      idx        <= '0;
      count_q    <= '0;
      settle_q   <= '0;
      settle_cnt <= '0;
      vec_rd     <= 1'b0;
      vec_addr   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            count_q  <= vec_count;
            settle_q <= settle_cycles;
            idx      <= '0;
            if (vec_count != '0) begin
              state    <= ST_FETCH;
              vec_rd   <= 1'b1;
              vec_addr <= '0;
            end
          end
        end
        ST_FETCH: begin
          vec_rd <= 1'b0;
          state  <= ST_LOAD;
        end
        ST_LOAD: begin
          settle_cnt <= settle_q;
          state      <= (settle_q == '0) ? ST_SAMPLE : ST_SETTLE;
        end
        ST_SETTLE: begin
          if (settle_cnt == SETTLE_W'(1)) begin
            state <= ST_SAMPLE;
          end else begin
            settle_cnt <= settle_cnt - 1'b1;
          end
        end
        ST_SAMPLE: begin
          if (cap_done) begin
            if (miss || last) begin
              state <= ST_IDLE;
            end else begin
              idx      <= idx + 1'b1;
              vec_addr <= idx + 1'b1;
              vec_rd   <= 1'b1;
              state    <= ST_FETCH;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  pvt_drive_former #(
    .PINS (PINS)
  ) u_drive (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .stim_i   (vec_stim),
    .expect_i (vec_expect),
    .care_i   (vec_care),
    .dout_i   (vec_dout),
    .drive_o  (pin_drive),
    .expect_o (exp_q),
    .care_o   (care_q)
  );

  pvt_capture #(
    .PINS  (PINS),
    .GRP_W (GRP_W)
  ) u_capture (
    .clk       (clk),
    .rst       (rst),
    .begin_i   (cap_begin),
    .rb_data_i (rb_data),
    .grp_sel_o (grp_sel),
    .cap_o     (cap_word),
    .done_o    (cap_done)
  );

  pvt_verdict #(
    .PINS   (PINS),
    .ADDR_W (ADDR_W)
  ) u_verdict (
    .clk          (clk),
    .rst          (rst),
    .clear_i      (accept),
    .empty_i      (vec_count == '0),
    .judge_i      (judge),
    .last_i       (last),
    .idx_i        (idx),
    .cap_i        (cap_word),
    .expect_i     (exp_q),
    .care_i       (care_q),
    .miss_o       (miss),
    .done_o       (done),
    .pass_o       (pass),
    .fail_index_o (fail_index),
    .fail_bits_o  (fail_bits)
  );

  // R11: each memory read is a single-cycle strobe
  p_rd_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    vec_rd |=> !vec_rd);

  // R3: socket drive is steady across the readback sweep
  p_sweep_stable_r3: assert property (@(posedge clk) disable iff (rst)
    (|grp_sel) |=> $stable(pin_drive));

  // R9: a start seen mid-run does not clear the verdict path
  p_busy_start_r9: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && start) |=> !$fell(done));

endmodule

// File: tb/pin_vector_tester_test.sv
`timescale 1ns/1ps
module pin_vector_tester_test;

  localparam int PINS = 24;
  localparam int GRP_W = 8;
  localparam int ADDR_W = 4;
  localparam int SETTLE_W = 4;
  localparam int NGRP = PINS / GRP_W;
  localparam int NTBL = 8;

  // entry = {readback value when disabled, 7'b0 + enable, data byte}
  localparam logic [23:0] TBL [NTBL] = '{
    {8'hFF, 8'h00, 8'h00},
    {8'h00, 8'h00, 8'hFF},
    {8'hA5, 8'h00, 8'h5A},
    {8'h00, 8'h01, 8'h3C},
    {8'h00, 8'h01, 8'hC3},
    {8'h00, 8'h01, 8'h01},
    {8'h7E, 8'h00, 8'h80},
    {8'h00, 8'h01, 8'hF0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [ADDR_W:0] vec_count = '0;
  logic [SETTLE_W-1:0] settle_cycles = '0;
  logic vec_rd;
  logic [ADDR_W-1:0] vec_addr;
  logic [PINS-1:0] pin_drive;
  logic [NGRP-1:0] grp_sel;
  logic [GRP_W-1:0] rb_data;
  logic done, pass;
  logic [ADDR_W-1:0] fail_index;
  logic [PINS-1:0] fail_bits;
  logic [4*PINS-1:0] mem [2**ADDR_W];
  logic [4*PINS-1:0] rdq = '0;
  logic [PINS-1:0] open_mask = '0;
  logic [PINS-1:0] sock;
  int rd_cnt = 0;
  int rd_last = 0;
  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  pin_vector_tester #(
    .PINS(PINS), .GRP_W(GRP_W), .ADDR_W(ADDR_W), .SETTLE_W(SETTLE_W)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .vec_count(vec_count),
    .settle_cycles(settle_cycles), .vec_rd(vec_rd), .vec_addr(vec_addr),
    .vec_stim(rdq[4*PINS-1:3*PINS]), .vec_expect(rdq[3*PINS-1:2*PINS]),
    .vec_care(rdq[2*PINS-1:PINS]), .vec_dout(rdq[PINS-1:0]),
    .pin_drive(pin_drive), .grp_sel(grp_sel), .rb_data(rb_data),
    .done(done), .pass(pass), .fail_index(fail_index), .fail_bits(fail_bits)
  );

  // vector memory, one cycle read latency, and read bookkeeping
  always @(posedge clk) begin
    if (vec_rd) rdq <= mem[vec_addr];
    if (start && !vec_rd) rd_cnt <= 0;
    else if (vec_rd) begin
      rd_cnt  <= rd_cnt + 1;
      rd_last <= int'(vec_addr);
    end
  end

  // socket model: pins 7:0 data in, pin 16 enable, pins 15:8 buffered
  // outputs when enabled, pins 23:17 return a fixed junk pattern
  always_comb begin
    sock[7:0]   = pin_drive[7:0];
    sock[16]    = pin_drive[16];
    sock[23:17] = 7'h55;
    for (int p = 0; p < 8; p++)
      sock[8+p] = (pin_drive[16] && !open_mask[8+p]) ? pin_drive[p] : pin_drive[8+p];
    if (grp_sel[0])      rb_data = sock[7:0];
    else if (grp_sel[1]) rb_data = sock[15:8];
    else if (grp_sel[2]) rb_data = sock[23:16];
    else                 rb_data = '0;
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      mismatched = mismatched + 1;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared = compared + 1;
    if (act !== exp) begin
      mismatched = mismatched + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [4*PINS-1:0] mk(input logic [23:0] t, input logic [PINS-1:0] cclr);
    logic [7:0] d, s;
    logic e;
    logic [PINS-1:0] st, ex, ca, dv;
    d = t[7:0]; e = t[8]; s = t[23:16];
    st = {7'b0, e, (e ? 8'h00 : s), d};
    ex = {7'b0, e, (e ? d : s), d};
    ca = 24'h01FFFF & ~cclr;
    dv = {8'h00, (e ? 8'hFF : 8'h00), 8'h00};
    return {st, ex, ca, dv};
  endfunction

  task automatic fill(input logic [PINS-1:0] cclr);
    for (int i = 0; i < 2**ADDR_W; i++) mem[i] = '0;
    for (int i = 0; i < NTBL; i++) mem[i] = mk(TBL[i], cclr);
  endtask

  logic done_after_start;

  task automatic run(input int cnt, input int s, input int extra_at,
                     output int tg, output int td);
    int n;
    tg = -1;
    @(negedge clk);
    vec_count = (ADDR_W+1)'(cnt);
    settle_cycles = SETTLE_W'(s);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    n = 0;
    done_after_start = done;
    if (grp_sel[0]) tg = 0;
    while (!done && n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      start = (n == extra_at);
      if (grp_sel[0] && tg < 0) tg = n;
    end
    start = 1'b0;
    td = n;
  endtask

  initial begin
    int tg, td;
    fill('0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1 done in reset", 32'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 done", 32'(done), 0);
    chk("R1 pass", 32'(pass), 0);
    chk("R1 grp_sel", 32'(grp_sel), 0);
    chk("R1 pin_drive", 32'(pin_drive), 0);
    chk("R1 vec_rd", 32'(vec_rd), 0);
    chk("R1 fail_bits", 32'(fail_bits), 0);

    // full passing list, settle 3
    run(8, 3, -1, tg, td);
    chk("R4 first strobe", 32'(tg), 5);
    chk("R6 run length", 32'(td), 72);
    chk("R6 pass", 32'(pass), 1);
    chk("R2 held drive enabled", 32'(pin_drive), 32'h010FF0);
    chk("R11 read count", 32'(rd_cnt), 8);
    chk("R11 last address", 32'(rd_last), 7);

    repeat (20) @(negedge clk);
    chk("R10 done held", 32'(done), 1);
    chk("R10 pass held", 32'(pass), 1);

    // zero settle, list ending on a disabled vector
    run(7, 0, -1, tg, td);
    chk("R10 start clears done", 32'(done_after_start), 0);
    chk("R4 first strobe zero settle", 32'(tg), 2);
    chk("R6 run length zero settle", 32'(td), 42);
    chk("R6 pass zero settle", 32'(pass), 1);
    chk("R2 held drive disabled", 32'(pin_drive), 32'h007E80);

    // open output on pin 11 first seen at vector 3
    open_mask = 24'h000800;
    run(8, 3, -1, tg, td);
    chk("R7 stop length", 32'(td), 36);
    chk("R7 done", 32'(done), 1);
    chk("R7 pass low", 32'(pass), 0);
    chk("R7 fail index", 32'(fail_index), 3);
    chk("R7 fail bits", 32'(fail_bits), 32'h000800);
    chk("R11 reads stop at failure", 32'(rd_cnt), 4);

    // same fault, pin 11 masked off everywhere
    fill(24'h000800);
    run(8, 3, -1, tg, td);
    chk("R5 masked pin pass", 32'(pass), 1);
    chk("R5 masked run length", 32'(td), 72);

    // two open pins, settle 1
    fill('0);
    open_mask = 24'h008100;
    run(8, 1, -1, tg, td);
    chk("R7 two pin length", 32'(td), 28);
    chk("R7 two pin index", 32'(fail_index), 3);
    chk("R7 two pin bits", 32'(fail_bits), 32'h008100);
    chk("R7 two pin pass low", 32'(pass), 0);

    // empty list right after a failing run
    run(0, 3, -1, tg, td);
    chk("R8 empty length", 32'(td), 0);
    chk("R8 empty done", 32'(done), 1);
    chk("R8 empty pass", 32'(pass), 1);

    // start pulse in the middle of a run
    open_mask = '0;
    run(8, 2, 10, tg, td);
    chk("R9 length unchanged", 32'(td), 64);
    chk("R9 verdict unchanged", 32'(pass), 1);
    chk("R9 strobe timing", 32'(tg), 4);

    summary();
    $finish;
  end

endmodule